// File: doc/BRIEF.md
# Drive level adjustment resolver

The resolver turns a sink's per-lane drive adjustment requests into one drive setting that all four lanes of a serial display link share. It receives a six-byte link status snapshot and the number of active lanes. Two of the snapshot bytes hold the requests, with one voltage-swing code and one pre-emphasis code for each lane. The resolver takes the largest swing and the largest pre-emphasis requested by any active lane. It clamps both to what the transmitter can drive and marks each clamp with a "limit reached" flag. The pre-emphasis ceiling depends on the swing that was chosen.

The result leaves the block in two forms. The first is a training byte, copied into all four lane slots, that the training sequencer writes back to the sink. The second is a compact signal-level code for the transmitter's port register, with separate swing and pre-emphasis fields.

Requests enter on a valid/ready stream and results leave on another. The block holds one result. It accepts a new snapshot when its output slot is empty or is being drained in the same cycle. A stalled result stays unchanged until the consumer takes it, so back-pressure from `out_ready` reaches `in_ready` in the same cycle.

Top module: `dla_resolver`

## Requirements
- R1: Status byte k sits at `in_status[8k+7:8k]`. The request for lane n is in byte 4 + n/2. An even lane uses bits 1:0 (swing) and 3:2 (pre-emphasis) of that byte. An odd lane uses bits 5:4 (swing) and 7:6 (pre-emphasis).
- R2: The chosen swing and the chosen pre-emphasis are each the largest code requested by lanes 0 to `in_lane_cnt`-1. Requests from the other lanes have no effect. A count above 4 counts as 4, and a count of 0 gives a request of zero.
- R3: The swing codes 0..3 mean 0.4/0.6/0.8/1.2 V. A swing request of code 2 or more becomes code 2, and the swing-limit flag (bit 2 of the training byte) is set. Otherwise the flag is clear.
- R4: The pre-emphasis codes 0..3 mean 0/3.5/6/9.5 dB. The ceiling is code 2 for swing 0 or 1, code 1 for swing 2 and code 0 for swing 3. A request at or above the ceiling becomes the ceiling, and the pre-emphasis-limit flag (bit 5) is set. Otherwise the flag is clear.
- R5: The training byte holds swing in bits 1:0 and pre-emphasis in bits 4:3, and bits 7:6 are zero. The same byte appears in all four slots of `out_train` (slot n at bits 8n+7:8n), whatever the lane count.
- R6: In `out_level`, bits 5:3 carry the swing field: 000, 010, 100, 110 for swing codes 0..3. Bits 2:0 carry the pre-emphasis field: 000, 001, 010, 011 for codes 0..3. An unrecognised code maps to the 0.4 V / 0 dB fields.
- R7: `in_ready` is high when no result is held or `out_ready` is high. A snapshot accepted on a clock edge appears with `out_valid` high right after that edge. A result leaves on an edge where `out_valid` and `out_ready` are both high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_train` and `out_level` hold their values.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Snapshot offered |
| in_ready | output | 1 | Snapshot can be taken this cycle |
| in_status | input | 48 | Six-byte link status snapshot, byte k at bits 8k+7:8k |
| in_lane_cnt | input | 3 | Number of active lanes |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_train | output | 32 | Four identical training bytes |
| out_level | output | 6 | Port signal-level code |

## Verification
The extraction is tested with a single nonzero request placed in each lane's nibble in turn. This tells a wrong byte index or a wrong half-byte apart from a correct lookup. Large requests are put on lanes just past the active count, with counts of 0, 1, 2, 4 and 7. This separates a correct lane mask from one that is off by one or that wraps. Swing/pre-emphasis pairs on both sides of each ceiling check that the ceiling follows the clamped swing and that each flag is set exactly at the boundary. A long random run with random `in_valid` and `out_ready` exercises stalls, back-to-back transfers and holding under back-pressure, against a queue-based model.

// File: rtl/dla_pkg.sv
package dla_pkg;

  typedef logic [1:0] lvl_t;

  localparam lvl_t SW_CAP = 2'd2;

  typedef struct packed {
    logic pe_lim;
    lvl_t pe;
    logic sw_lim;
    lvl_t sw;
  } train_t;

  localparam int TRAIN_W = $bits(train_t);
  localparam int BYTE_W  = 8;

  function automatic lvl_t pe_ceiling(input lvl_t sw);
    case (sw)
      2'd0, 2'd1: pe_ceiling = 2'd2;
      2'd2:       pe_ceiling = 2'd1;
      default:    pe_ceiling = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/dla_lane_extract.sv
module dla_lane_extract
  import dla_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int STATUS_BYTES = 6,
  parameter int ADJ_BASE     = 4,
  parameter int LC_W         = 3
) (
  input  logic [8*STATUS_BYTES-1:0] status,
  input  logic [LC_W-1:0]           lane_cnt,
  output lvl_t                      lane_sw [NUM_LANES],
  output lvl_t                      lane_pe [NUM_LANES]
);

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    localparam int BIDX  = ADJ_BASE + n / 2;
    localparam int SHIFT = (n % 2) * 4;
    logic [7:0] req_byte;
    logic       active;
    assign req_byte   = status[8*BIDX +: 8];
    assign active     = (32'(lane_cnt) > n);
    assign lane_sw[n] = active ? req_byte[SHIFT +: 2]     : 2'd0;
    assign lane_pe[n] = active ? req_byte[SHIFT + 2 +: 2] : 2'd0;
  end

endmodule

// File: rtl/dla_max_clamp.sv
module dla_max_clamp
  import dla_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  lvl_t   lane_sw [NUM_LANES],
  input  lvl_t   lane_pe [NUM_LANES],
  output train_t setting
);

  lvl_t max_sw, max_pe, cap_sw, ceil_pe;

  always_comb begin
    max_sw = 2'd0;
    max_pe = 2'd0;
    for (int n = 0; n < NUM_LANES; n++) begin
      if (lane_sw[n] > max_sw) max_sw = lane_sw[n];
      if (lane_pe[n] > max_pe) max_pe = lane_pe[n];
    end
  end

  always_comb begin
    setting = '0;
    if (max_sw >= SW_CAP) begin
      cap_sw         = SW_CAP;
      setting.sw_lim = 1'b1;
    end else begin
      cap_sw = max_sw;
    end
    setting.sw = cap_sw;
    ceil_pe    = pe_ceiling(cap_sw);
    if (max_pe >= ceil_pe) begin
      setting.pe     = ceil_pe;
      setting.pe_lim = 1'b1;
    end else begin
      setting.pe = max_pe;
    end
  end

endmodule

// File: rtl/dla_level_map.sv
module dla_level_map
  import dla_pkg::*;
(
  input  train_t     setting,
  output logic [5:0] level
);

  logic [2:0] sw_f, pe_f;

  always_comb begin
    case (setting.sw)
      2'd1:    sw_f = 3'b010;
      2'd2:    sw_f = 3'b100;
      2'd3:    sw_f = 3'b110;
      default: sw_f = 3'b000;
    endcase
    case (setting.pe)
      2'd1:    pe_f = 3'b001;
      2'd2:    pe_f = 3'b010;
      2'd3:    pe_f = 3'b011;
      default: pe_f = 3'b000;
    endcase
  end

  assign level = {sw_f, pe_f};

endmodule

// File: rtl/dla_resolver.sv
module dla_resolver
  import dla_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int STATUS_BYTES = 6,
  parameter int ADJ_BASE     = 4,
  parameter int LC_W         = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [8*STATUS_BYTES-1:0]     in_status,
  input  logic [LC_W-1:0]               in_lane_cnt,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BYTE_W*NUM_LANES-1:0]   out_train,
  output logic [5:0]                    out_level
);

  localparam int PAD_W = BYTE_W - TRAIN_W;

  lvl_t       lane_sw [NUM_LANES];
  lvl_t       lane_pe [NUM_LANES];
  train_t     setting;
  logic [5:0] level_c;
  logic [BYTE_W*NUM_LANES-1:0] train_c;

  dla_lane_extract #(
    .NUM_LANES(NUM_LANES), .STATUS_BYTES(STATUS_BYTES),
    .ADJ_BASE(ADJ_BASE), .LC_W(LC_W)
  ) u_extract (
    .status(in_status), .lane_cnt(in_lane_cnt),
    .lane_sw(lane_sw), .lane_pe(lane_pe)
  );

  dla_max_clamp #(.NUM_LANES(NUM_LANES)) u_clamp (
    .lane_sw(lane_sw), .lane_pe(lane_pe), .setting(setting)
  );

  dla_level_map u_map (.setting(setting), .level(level_c));

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_slot
    assign train_c[BYTE_W*n +: BYTE_W] = {{PAD_W{1'b0}}, setting};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_train <= '0;
      out_level <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_train <= train_c;
        out_level <= level_c;
      end
    end
  end

  // R8: a stalled result is held
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_train) && $stable(out_level));

  // R3: flagged swing sits exactly at the cap; swing never beyond the cap
  assert_swing_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_train[1:0] <= SW_CAP && (!out_train[2] || out_train[1:0] == SW_CAP));

  // R4: pre-emphasis never above the ceiling for the held swing
  assert_pe_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_train[4:3] <= pe_ceiling(out_train[1:0]) &&
                  (!out_train[5] || out_train[4:3] == pe_ceiling(out_train[1:0])));

  // R5: every slot carries the same byte
  assert_same_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_train == {NUM_LANES{out_train[7:0]}});

  // R6: level code agrees with the training byte
  assert_level_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_level[5:3] == {out_train[1:0], 1'b0} &&
                  out_level[2:0] == {1'b0, out_train[4:3]});

endmodule

// File: tb/tb_dla_resolver.sv
module tb_dla_resolver;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [47:0] in_status;
  logic [2:0]  in_lane_cnt;
  logic [31:0] out_train;
  logic [5:0]  out_level;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] q_train [$];
  logic [5:0]  q_level [$];
  string       q_tag   [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dla_resolver dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_status(in_status), .in_lane_cnt(in_lane_cnt), .out_valid(out_valid),
    .out_ready(out_ready), .out_train(out_train), .out_level(out_level)
  );

  function automatic logic [47:0] req(input int lane, input int sw, input int pe);
    logic [47:0] s = '0;
    int bit0 = 8 * (4 + lane / 2) + (lane % 2) * 4;
    s[bit0 +: 2]     = 2'(sw);
    s[bit0 + 2 +: 2] = 2'(pe);
    return s;
  endfunction

  task automatic model(input logic [47:0] st, input int lc,
                       output logic [31:0] tr, output logic [5:0] lv);
    int v = 0, p = 0, n, ceil_v;
    bit fs = 0, fp = 0;
    logic [7:0] b;
    n = (lc > 4) ? 4 : lc;
    for (int l = 0; l < n; l++) begin
      int by = st[8*(4 + l/2) +: 8];
      int sh = (l % 2) * 4;
      if (((by >> sh) & 3) > v) v = (by >> sh) & 3;
      if (((by >> (sh + 2)) & 3) > p) p = (by >> (sh + 2)) & 3;
    end
    if (v >= 2) begin v = 2; fs = 1; end
    ceil_v = (v < 2) ? 2 : ((v == 2) ? 1 : 0);
    if (p >= ceil_v) begin p = ceil_v; fp = 1; end
    b  = 8'(v + fs * 4 + p * 8 + fp * 32);
    tr = {b, b, b, b};
    lv = 6'((v * 2) * 8 + p);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive after a negedge, model the edge, check at next negedge
  task automatic step(input logic iv, input logic [47:0] st, input logic [2:0] lc,
                      input logic ordy, input string tag, output bit taken);
    bit held, popped, stall;
    logic [31:0] et; logic [5:0] el;
    in_valid = iv; in_status = st; in_lane_cnt = lc; out_ready = ordy;
    #1;
    held = (q_train.size() != 0);
    check(in_ready == (!held || ordy), "R7 in_ready", 64'(in_ready), 64'(!held || ordy));
    taken  = iv && (!held || ordy);
    popped = held && ordy;
    stall  = held && !ordy;
    if (popped) begin void'(q_train.pop_front()); void'(q_level.pop_front()); void'(q_tag.pop_front()); end
    if (taken) begin
      model(st, int'(lc), et, el);
      q_train.push_back(et); q_level.push_back(el); q_tag.push_back(tag);
    end
    @(negedge clk);
    if (q_train.size() != 0) begin
      string t = stall ? "R8 hold" : q_tag[0];
      check(out_valid == 1'b1, {t, " R7 valid"}, 64'(out_valid), 64'd1);
      check(out_train == q_train[0], {t, " R5 train"}, 64'(out_train), 64'(q_train[0]));
      check(out_level == q_level[0], {t, " R6 level"}, 64'(out_level), 64'(q_level[0]));
    end else begin
      check(out_valid == 1'b0, "R7 empty", 64'(out_valid), 64'd0);
    end
  endtask

  task automatic send(input logic [47:0] st, input logic [2:0] lc, input string tag);
    bit tk;
    step(1'b1, st, lc, 1'b1, tag, tk);
    if (!tk) check(1'b0, {tag, " R7 accept"}, 64'd0, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit tk;
    rst_n = 1'b0; in_valid = 1'b0; in_status = '0; in_lane_cnt = 3'd4; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R9 reset ready", 64'(in_ready), 64'd1);
    @(negedge clk);

    // R1: one lane requests at a time
    for (int l = 0; l < 4; l++) send(req(l, 1, 1), 3'd4, "R1 lane");
    send(req(1, 0, 2) | req(2, 1, 0), 3'd4, "R1 mixed");
    send(48'h0000_3333_3333, 3'd4, "R1 non-request bytes");

    // R2: masked lanes and odd counts
    send(req(2, 3, 3) | req(3, 3, 3), 3'd2, "R2 upper lanes masked");
    send(req(1, 3, 0), 3'd1, "R2 lane1 masked");
    send(req(0, 1, 1), 3'd0, "R2 zero lanes");
    send(req(3, 1, 1), 3'd7, "R2 count above four");
    send(req(0, 1, 0) | req(3, 0, 1), 3'd4, "R2 max across lanes");

    // R3: swing clamp
    send(req(0, 2, 0), 3'd1, "R3 swing at cap");
    send(req(0, 3, 0), 3'd1, "R3 swing above cap");
    send(req(0, 1, 0), 3'd1, "R3 swing below cap");

    // R4: ceiling tracks swing
    send(req(0, 0, 2), 3'd1, "R4 pe at ceiling");
    send(req(0, 0, 3), 3'd1, "R4 pe above ceiling");
    send(req(0, 1, 1), 3'd1, "R4 pe below ceiling");
    send(req(0, 2, 1), 3'd1, "R4 pe at 0.8V ceiling");
    send(req(0, 3, 3), 3'd1, "R4 both clamped");
    send(req(0, 2, 0), 3'd1, "R4 pe zero at 0.8V");

    // R8: stall holds a result
    send(req(0, 1, 2), 3'd4, "R8 stall setup");
    for (int k = 0; k < 3; k++) step(1'b1, req(0, 3, 3), 3'd4, 1'b0, "R8 blocked", tk);
    step(1'b0, '0, 3'd4, 1'b1, "R7 drain", tk);

    // random traffic with back-pressure
    for (int k = 0; k < 600; k++) begin
      logic [47:0] st = {$urandom, $urandom};
      step(1'($urandom % 4 != 0), st, 3'($urandom), 1'($urandom % 3 != 0), "R2 random", tk);
    end
    step(1'b0, '0, 3'd4, 1'b1, "R7 drain", tk);
    step(1'b0, '0, 3'd4, 1'b1, "R7 drain", tk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule